// File: doc/BRIEF.md
# UART Register Interface

This block is the software-facing register shell of a serial port. A simple single-cycle bus reads and writes a set of word registers selected by a six-bit byte offset. The line-format, general-control, FIFO-control, modem-control and baud-divisor words are stored and read back, some of them through fixed masks. The remaining offsets return constant or nearly constant status words. Bit-level serialization, baud timing and multi-entry FIFOs are handled elsewhere. Here the transmit side is a byte strobe, and the receive side is a byte stream with a ready signal.

Received bytes land in a one-byte holding register with an "available" flag. Software drains it by reading the receive-holding offset. A loopback bit in general control diverts bytes written for transmission into the same holding register. Each direction has its own interrupt. A general-control bit chooses whether that interrupt is a one-clock pulse or a level that stays up until software clears it.

Top module: `uart_regif`

## Requirements
- R1: Synchronous active-high reset clears every stored control word, the available flag and all outputs. After reset, rx_ready is 1, a status read at offset 0x10 returns 0x6, and a general-control read at offset 0x04 returns 0.
- R2: The line-format word (offset 0x00), the general-control word (0x04) and the baud-divisor word (0x28) each store all 32 written bits and read them back unchanged.
- R3: A write to FIFO control (0x08) stores the value with bits 1 and 2 cleared. A read of it returns the stored value with bit 3 forced to 0, so writing 0xFFFFFFFF reads back 0xFFFFFFF1.
- R4: A read of modem control (0x0C) returns only bits 0 and 4 of the stored value; all other bits read 0.
- R5: A read of offset 0x10 returns 0x6 OR the available flag in bit 0. A read of 0x18 returns the available flag in bit 0. Offsets 0x14, 0x1C and 0x20, and all unmapped offsets, read 0. Writes to read-only or unmapped offsets change nothing.
- R6: A write to the transmit-holding offset (0x20) while general-control bit 5 is 0 raises tx_valid for exactly the next cycle. In that cycle tx_byte holds the low 8 bits of the written data.
- R7: A write to 0x20 while general-control bit 5 is 1 produces no tx_valid. Instead it loads the low byte into the holding register and sets the available flag, overwriting any byte already held, and raises the receive interrupt.
- R8: rx_ready is the inverse of the available flag. A byte presented with rx_valid is taken only while rx_ready is 1. A byte presented while a byte is held is ignored and does not change the held byte.
- R9: When a byte is loaded into the holding register, from outside or by loopback, and general-control bit 8 is 1, rx_level goes high the next cycle. When bit 8 is 0, rx_pulse is high for exactly the next cycle instead.
- R10: After every write to 0x20, tx_level is high the next cycle if general-control bit 9 is 1. Otherwise tx_pulse is high for exactly the next cycle.
- R11: A write to general control sets tx_level to the written bit 9 from the next cycle on. If the written bit 8 is 0, rx_level is cleared; if it is 1, rx_level keeps its value.
- R12: A read of receive holding (0x24) returns the held byte in bits 7:0 and clears the available flag. If general-control bit 8 is 1, the read also clears rx_level.
- R13: If a general-control write and a receive load occur in the same cycle, the newly written bits 8 and 9 decide pulse or level for that load. If a loopback write and an external byte arrive in the same cycle, the loopback byte is held and the external byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the request cycle |
| tx_valid | output | 1 | One-cycle strobe for a byte to transmit |
| tx_byte | output | BYTE_W | Byte to transmit |
| rx_valid | input | 1 | Incoming byte present |
| rx_byte | input | BYTE_W | Incoming byte |
| rx_ready | output | 1 | Holding register is empty and can take a byte |
| tx_pulse | output | 1 | Transmit interrupt, pulse form |
| tx_level | output | 1 | Transmit interrupt, level form |
| rx_pulse | output | 1 | Receive interrupt, pulse form |
| rx_level | output | 1 | Receive interrupt, level form |

## Verification
The bus and the receive stream are independent, so a general-control write can land in the same cycle that an external byte is accepted. Likewise, a loopback write to the transmit-holding offset can coincide with an arriving byte. The bench drives both inputs in one cycle, once with the interrupt mode switched from level to pulse and once from pulse to level. It checks that the pulse or level seen on the next cycle follows the newly written mode. For the loopback collision, it checks that the held byte read back is the looped byte and that the available flag clears after a single read.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int unsigned ADDR_W = 6;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_LINE  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_GEN   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_FIFO  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_MODEM = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ERR   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_FSTAT = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_TXH   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_RXH   = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_BAUD  = 6'h28;

  // general-control bit positions
  localparam int unsigned GEN_LOOP_BIT  = 5;
  localparam int unsigned GEN_RXLVL_BIT = 8;
  localparam int unsigned GEN_TXLVL_BIT = 9;

  // fixed masks and constants
  localparam int unsigned FIFO_WR_CLR   = 6;     // bits 1,2 dropped on write
  localparam int unsigned FIFO_RD_BIT   = 3;     // forced zero on read
  localparam int unsigned MODEM_RD_KEEP = 'h11;  // bits 0 and 4
  localparam int unsigned STAT_TX_IDLE  = 6;     // transmitter empty bits

  // stored control words
  localparam int unsigned NCTL      = 5;
  localparam int unsigned IDX_LINE  = 0;
  localparam int unsigned IDX_GEN   = 1;
  localparam int unsigned IDX_FIFO  = 2;
  localparam int unsigned IDX_MODEM = 3;
  localparam int unsigned IDX_BAUD  = 4;

  typedef struct packed {
    logic [NCTL-1:0] ctl_we;
    logic            txh_we;
    logic            rxh_rd;
  } bus_dec_t;

endpackage

// File: rtl/uart_regif_dec.sv
module uart_regif_dec
  import uart_regif_pkg::*;
(
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output bus_dec_t          dec
);

  always_comb begin
    dec = '0;
    if (sel && wr) begin
      case (addr)
        OFS_LINE:  dec.ctl_we[IDX_LINE]  = 1'b1;
        OFS_GEN:   dec.ctl_we[IDX_GEN]   = 1'b1;
        OFS_FIFO:  dec.ctl_we[IDX_FIFO]  = 1'b1;
        OFS_MODEM: dec.ctl_we[IDX_MODEM] = 1'b1;
        OFS_BAUD:  dec.ctl_we[IDX_BAUD]  = 1'b1;
        OFS_TXH:   dec.txh_we            = 1'b1;
        default:   ;
      endcase
    end
    if (sel && !wr && (addr == OFS_RXH)) dec.rxh_rd = 1'b1;
  end

endmodule

// File: rtl/uart_regif_ctlregs.sv
module uart_regif_ctlregs
  import uart_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 32
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NCTL-1:0]              we,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NCTL-1:0][DATA_W-1:0]  q,
  output logic                         rx_mode_eff,
  output logic                         tx_mode_eff
);

  for (genvar i = 0; i < NCTL; i++) begin : g_reg
    localparam logic [DATA_W-1:0] WMASK =
      (i == IDX_FIFO) ? ~(DATA_W'(FIFO_WR_CLR)) : {DATA_W{1'b1}};
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)        r <= '0;
      else if (we[i]) r <= wdata & WMASK;
    end
    assign q[i] = r;
  end

  // mode bits in force this cycle: a same-cycle write wins
  assign rx_mode_eff = we[IDX_GEN] ? wdata[GEN_RXLVL_BIT] : q[IDX_GEN][GEN_RXLVL_BIT];
  assign tx_mode_eff = we[IDX_GEN] ? wdata[GEN_TXLVL_BIT] : q[IDX_GEN][GEN_TXLVL_BIT];

endmodule

// File: rtl/uart_regif_rxhold.sv
module uart_regif_rxhold #(
  parameter int unsigned BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              loop_we,
  input  logic [BYTE_W-1:0] loop_byte,
  input  logic              ext_valid,
  input  logic [BYTE_W-1:0] ext_byte,
  input  logic              rd_clr,
  output logic              avail,
  output logic [BYTE_W-1:0] data,
  output logic              load
);

  logic ext_take;

  assign ext_take = ext_valid && !avail;
  assign load     = loop_we || ext_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      avail <= 1'b0;
      data  <= '0;
    end else begin
      if (rd_clr) avail <= 1'b0;
      if (load) begin
        avail <= 1'b1;
        data  <= loop_we ? loop_byte : ext_byte;
      end
    end
  end

endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq #(
  parameter bit FOLLOW_CFG = 1'b0  // 1: level copies mode on a config write
)(
  input  logic clk,
  input  logic rst,
  input  logic ev,
  input  logic mode,
  input  logic cfg_we,
  input  logic rd_clr,
  output logic pulse,
  output logic level
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      level <= 1'b0;
    end else begin
      pulse <= ev && !mode;
      if (cfg_we) begin
        if (FOLLOW_CFG)  level <= mode;
        else if (!mode)  level <= 1'b0;
      end
      if (rd_clr && mode) level <= 1'b0;
      if (ev && mode)     level <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_regif_rdmux.sv
module uart_regif_rdmux
  import uart_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
)(
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NCTL-1:0][DATA_W-1:0] ctl_q,
  input  logic                        avail,
  input  logic [BYTE_W-1:0]           hold_byte,
  output logic [DATA_W-1:0]           rdata
);

  localparam logic [DATA_W-1:0] FIFO_RD_MASK  = ~(DATA_W'(1) << FIFO_RD_BIT);
  localparam logic [DATA_W-1:0] MODEM_RD_MASK = DATA_W'(MODEM_RD_KEEP);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_LINE:  rdata = ctl_q[IDX_LINE];
        OFS_GEN:   rdata = ctl_q[IDX_GEN];
        OFS_FIFO:  rdata = ctl_q[IDX_FIFO] & FIFO_RD_MASK;
        OFS_MODEM: rdata = ctl_q[IDX_MODEM] & MODEM_RD_MASK;
        OFS_STAT:  rdata = DATA_W'(STAT_TX_IDLE) | DATA_W'(avail);
        OFS_FSTAT: rdata = DATA_W'(avail);
        OFS_RXH:   rdata = DATA_W'(hold_byte);
        OFS_BAUD:  rdata = ctl_q[IDX_BAUD];
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_pulse,
  output logic              tx_level,
  output logic              rx_pulse,
  output logic              rx_level
);

  bus_dec_t                       dec;
  logic [NCTL-1:0][DATA_W-1:0]    ctl_q;
  logic                           rx_mode_eff;
  logic                           tx_mode_eff;
  logic                           loop_on;
  logic                           avail;
  logic [BYTE_W-1:0]              hold_byte;
  logic                           rx_load;
  logic                           send_we;

  uart_regif_dec u_dec (
    .sel  (bus_sel),
    .wr   (bus_wr),
    .addr (bus_addr),
    .dec  (dec)
  );

  uart_regif_ctlregs #(.DATA_W(DATA_W)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .we          (dec.ctl_we),
    .wdata       (bus_wdata),
    .q           (ctl_q),
    .rx_mode_eff (rx_mode_eff),
    .tx_mode_eff (tx_mode_eff)
  );

  assign loop_on = ctl_q[IDX_GEN][GEN_LOOP_BIT];
  assign send_we = dec.txh_we && !loop_on;

  uart_regif_rxhold #(.BYTE_W(BYTE_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .loop_we   (dec.txh_we && loop_on),
    .loop_byte (bus_wdata[BYTE_W-1:0]),
    .ext_valid (rx_valid),
    .ext_byte  (rx_byte),
    .rd_clr    (dec.rxh_rd),
    .avail     (avail),
    .data      (hold_byte),
    .load      (rx_load)
  );

  assign rx_ready = !avail;

  uart_regif_irq #(.FOLLOW_CFG(1'b1)) u_tx_irq (
    .clk    (clk),
    .rst    (rst),
    .ev     (dec.txh_we),
    .mode   (tx_mode_eff),
    .cfg_we (dec.ctl_we[IDX_GEN]),
    .rd_clr (1'b0),
    .pulse  (tx_pulse),
    .level  (tx_level)
  );

  uart_regif_irq #(.FOLLOW_CFG(1'b0)) u_rx_irq (
    .clk    (clk),
    .rst    (rst),
    .ev     (rx_load),
    .mode   (rx_mode_eff),
    .cfg_we (dec.ctl_we[IDX_GEN]),
    .rd_clr (dec.rxh_rd),
    .pulse  (rx_pulse),
    .level  (rx_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= send_we;
      if (send_we) tx_byte <= bus_wdata[BYTE_W-1:0];
    end
  end

  uart_regif_rdmux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rd (
    .rd_en     (bus_sel && !bus_wr),
    .addr      (bus_addr),
    .ctl_q     (ctl_q),
    .avail     (avail),
    .hold_byte (hold_byte),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 32
)(
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wdata_txlvl,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_pulse,
  input logic              tx_level,
  input logic              rx_pulse,
  input logic              rx_level,
  input logic              loop_on
);

  logic wr_txh, wr_gen, rd_rxh, rd_stat;
  assign wr_txh  = bus_sel && bus_wr && (bus_addr == OFS_TXH);
  assign wr_gen  = bus_sel && bus_wr && (bus_addr == OFS_GEN);
  assign rd_rxh  = bus_sel && !bus_wr && (bus_addr == OFS_RXH);
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == OFS_STAT);

  // R5: status word tracks the holding register
  assert_status_word_R5: assert property (@(posedge clk) disable iff (rst)
    rd_stat |-> (bus_rdata == (DATA_W'(STAT_TX_IDLE) | DATA_W'(!rx_ready))));

  // R6: a transmit strobe only follows a non-loopback send write
  assert_tx_strobe_src_R6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(wr_txh && !loop_on));

  // R7: loopback writes never reach the transmit output
  assert_loop_no_tx_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_txh && loop_on) |=> (!tx_valid && !rx_ready));

  // R8: an accepted byte closes the ready window
  assert_accept_closes_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready) |=> !rx_ready);

  // R9: pulse and level forms are never up together
  assert_rx_irq_excl_R9: assert property (@(posedge clk) disable iff (rst)
    rx_pulse |-> !rx_level);

  // R10: each send write raises one of the transmit interrupt forms
  assert_tx_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    wr_txh |=> (tx_pulse || tx_level));

  // R11: tx level copies the written mode bit
  assert_tx_level_cfg_R11: assert property (@(posedge clk) disable iff (rst)
    wr_gen |=> (tx_level == $past(wdata_txlvl)));

  // R12: draining the holding register reopens it
  assert_drain_reopens_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_rxh && !rx_valid) |=> rx_ready);

endmodule

bind uart_regif uart_regif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .wdata_txlvl (bus_wdata[uart_regif_pkg::GEN_TXLVL_BIT]),
  .bus_rdata   (bus_rdata),
  .tx_valid    (tx_valid),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .tx_pulse    (tx_pulse),
  .tx_level    (tx_level),
  .rx_pulse    (rx_pulse),
  .rx_level    (rx_level),
  .loop_on     (loop_on)
);

// File: tb/uart_regif_tb.sv
module uart_regif_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, tx_pulse, tx_level, rx_pulse, rx_level;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  uart_regif u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_ready(rx_ready), .tx_pulse(tx_pulse),
    .tx_level(tx_level), .rx_pulse(rx_pulse), .rx_level(rx_level)
  );

  // {write, offset, write data, expected read}
  localparam int NV = 21;
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 6'h00, 32'hA5A51234, 32'h0},
    {1'b0, 6'h00, 32'h0,        32'hA5A51234},
    {1'b1, 6'h28, 32'hDEADBEEF, 32'h0},
    {1'b0, 6'h28, 32'h0,        32'hDEADBEEF},
    {1'b1, 6'h04, 32'h0000F0C1, 32'h0},
    {1'b0, 6'h04, 32'h0,        32'h0000F0C1},
    {1'b1, 6'h08, 32'hFFFFFFFF, 32'h0},
    {1'b0, 6'h08, 32'h0,        32'hFFFFFFF1},
    {1'b1, 6'h08, 32'h00000006, 32'h0},
    {1'b0, 6'h08, 32'h0,        32'h0},
    {1'b1, 6'h0C, 32'hFFFFFFFF, 32'h0},
    {1'b0, 6'h0C, 32'h0,        32'h00000011},
    {1'b1, 6'h10, 32'hFFFFFFFF, 32'h0},
    {1'b0, 6'h10, 32'h0,        32'h00000006},
    {1'b0, 6'h14, 32'h0,        32'h0},
    {1'b0, 6'h18, 32'h0,        32'h0},
    {1'b0, 6'h1C, 32'h0,        32'h0},
    {1'b0, 6'h20, 32'h0,        32'h0},
    {1'b1, 6'h3C, 32'h00001234, 32'h0},
    {1'b0, 6'h3C, 32'h0,        32'h0},
    {1'b0, 6'h2C, 32'h0,        32'h0}
  };

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00, 6'h04, 6'h28: return "R2";
      6'h08:               return "R3";
      6'h0C:               return "R4";
      default:             return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rxsend(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // bus write and incoming byte in the same cycle
  task automatic collide(input logic [5:0] a, input logic [31:0] d, input logic [7:0] b);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rx_ready", 32'(rx_ready), 32'h1);
    chk("R1 outputs", {27'b0, tx_valid, tx_pulse, tx_level, rx_pulse, rx_level}, 32'h0);
    bread(6'h10, d); chk("R1 status", d, 32'h6);
    bread(6'h04, d); chk("R1 gen", d, 32'h0);

    // table walk: R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][70]) bwrite(VEC[k][69:64], VEC[k][63:32]);
      else begin
        bread(VEC[k][69:64], d);
        chk(tag_of(VEC[k][69:64]), d, VEC[k][31:0]);
      end
    end
    bwrite(6'h04, 32'h0);

    // R6 / R10 send, pulse mode
    bwrite(6'h20, 32'h1C3);
    chk("R6 tx_valid", 32'(tx_valid), 32'h1);
    chk("R6 tx_byte", 32'(tx_byte), 32'hC3);
    chk("R10 tx_pulse", 32'(tx_pulse), 32'h1);
    chk("R10 tx_level", 32'(tx_level), 32'h0);
    chk("R6 no loopback", 32'(rx_ready), 32'h1);
    @(negedge clk);
    chk("R6 strobe one cycle", 32'(tx_valid), 32'h0);
    chk("R10 pulse one cycle", 32'(tx_pulse), 32'h0);

    // R10 / R11 level mode for transmit
    bwrite(6'h04, 32'h200);
    chk("R11 tx_level set", 32'(tx_level), 32'h1);
    bwrite(6'h20, 32'h11);
    chk("R10 level no pulse", {tx_valid, tx_pulse, tx_level}, 3'b101);
    bwrite(6'h04, 32'h0);
    chk("R11 tx_level clear", 32'(tx_level), 32'h0);

    // R8 / R9 external receive, pulse mode
    rxsend(8'h5A);
    chk("R9 rx_pulse", {rx_pulse, rx_level}, 2'b10);
    chk("R8 ready low", 32'(rx_ready), 32'h0);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(rx_pulse), 32'h0);
    bread(6'h10, d); chk("R5 status avail", d, 32'h7);
    bread(6'h18, d); chk("R5 fifo avail", d, 32'h1);
    rxsend(8'h77);
    chk("R8 ignored no irq", 32'(rx_pulse), 32'h0);
    bread(6'h24, d); chk("R12 hold byte kept R8", d, 32'h5A);
    chk("R12 drained", 32'(rx_ready), 32'h1);

    // R9 / R12 level mode for receive
    bwrite(6'h04, 32'h100);
    rxsend(8'h33);
    chk("R9 rx_level", {rx_pulse, rx_level}, 2'b01);
    bread(6'h24, d); chk("R12 byte", d, 32'h33);
    chk("R12 level cleared", {rx_level, rx_ready}, 2'b01);

    // R11 general-control effect on rx level
    rxsend(8'h44);
    bwrite(6'h04, 32'h300);
    chk("R11 level kept", {rx_level, tx_level}, 2'b11);
    bwrite(6'h04, 32'h0);
    chk("R11 level dropped", {rx_level, tx_level, rx_ready}, 3'b000);
    bread(6'h24, d); chk("R11 byte still held", d, 32'h44);

    // R7 loopback
    bwrite(6'h04, 32'h20);
    bwrite(6'h20, 32'h4E);
    chk("R7 looped", {tx_valid, rx_pulse, tx_pulse, rx_ready}, 4'b0110);
    bwrite(6'h20, 32'h19F);
    chk("R7 overwrite irq", 32'(rx_pulse), 32'h1);
    bread(6'h24, d); chk("R7 overwritten byte", d, 32'h9F);

    // R13 same-cycle collisions
    bwrite(6'h04, 32'h100);
    collide(6'h04, 32'h0, 8'h61);
    chk("R13 new mode pulse", {rx_pulse, rx_level, rx_ready}, 3'b100);
    bread(6'h24, d); chk("R13 byte a", d, 32'h61);
    collide(6'h04, 32'h100, 8'h62);
    chk("R13 new mode level", {rx_pulse, rx_level}, 2'b01);
    bread(6'h24, d); chk("R13 byte b", d, 32'h62);
    bwrite(6'h04, 32'h20);
    collide(6'h20, 32'hAB, 8'h12);
    chk("R13 loop wins irq", {rx_pulse, rx_ready}, 2'b10);
    bread(6'h24, d); chk("R13 loop byte", d, 32'hAB);
    bread(6'h10, d); chk("R13 external dropped", d, 32'h6);

    // R1 reset mid-operation
    bwrite(6'h04, 32'h300);
    rxsend(8'h99);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1 levels after reset", {tx_level, rx_level, rx_ready}, 3'b001);
    bread(6'h04, d); chk("R1 gen cleared", d, 32'h0);
    bread(6'h28, d); chk("R1 baud cleared", d, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule